// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects up to `N_SRC` external interrupt request lines and decides which one a processor should service next. Each source keeps an enable bit, a pending bit, an active bit and a 4-bit priority. Software reaches all of this state through a single word-wide write/read port. A 3-bit grouping field splits every priority, from the top down, into preemption bits and sub bits. The preemption bits decide whether a request may interrupt a running handler. The sub bits only order requests that compete at the same moment.

Each cycle the controller looks for the most urgent enabled, pending source that is not already active. It accepts that source when its preemption value is strictly more urgent than that of the running handler. On acceptance it pulses `take_o` with the source index, clears the source's pending bit, sets its active bit and pushes the index onto an internal nesting stack. The running priority always comes from the top of that stack. A one-cycle `eoi_i` strobe retires the most recently accepted handler, and control returns to the handler below it.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, every enable, pending and active bit reads 0, the grouping field reads 0, every priority reads 0 and `take_o` is low.
- R2: Source i has a priority byte at address 0x40+i. A write stores only data bits [7:4]. A read returns the stored nibble in bits [7:4], with bits [3:0] and [31:8] reading zero. A numerically lower nibble is more urgent.
- R3: The grouping field sits at address 0x20, in bits [2:0]. Its value gives the preemption:sub split as follows, with the preemption bits always taken from the top of the nibble: 7 gives 0:4, 6 gives 1:3, 5 gives 2:2, 4 gives 3:1, and 3 or any lower value gives 4:0.
- R4: The enable set register is at 0x00+k and the enable clear register is at 0x04+k. Word k covers sources 32k to 32k+31, with source 32k+j in data bit j. Writing 1 to a bit sets or clears that source's enable, and writing 0 has no effect. Reading either address returns the enable word.
- R5: The pending set register is at 0x08+k and the pending clear register is at 0x0C+k, laid out like R4. Writing 1 sets or clears the pending bit, and writing 0 has no effect. Reading either address returns the pending word.
- R6: A rising edge on `irq_i[i]` sets pending bit i even while source i is disabled. A disabled source is never accepted. A line held high does not set pending again after acceptance.
- R7: The active register at 0x10+k is read-only. A source's active bit is set only when that source is accepted, and it is cleared by the `eoi_i` that retires it.
- R8: Acceptance happens in the same cycle in which a candidate first qualifies. `take_o` is high for that cycle and `take_id_o` carries the index. At the following clock edge the pending bit clears and the active bit sets. With no handler active, any enabled pending source is accepted. Otherwise a source is accepted only when its preemption value is strictly more urgent than the running handler's, so nesting occurs.
- R9: A request whose preemption value equals the running handler's is not accepted until that handler retires, even if its sub value is more urgent.
- R10: Among competing requests, the lowest preemption value wins, then the lowest sub value, then the lowest source index.
- R11: `eoi_i` retires the most recently accepted handler, and the previous handler's priority becomes the running one. No source is accepted in a cycle in which `eoi_i` is high.
- R12: A write to the grouping field affects acceptance from the next cycle on, comparing the running handler under the new split. The nesting stack and the active bits are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_SRC | Request lines; a rising edge sets pending |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational from addr_i) |
| take_o | output | 1 | A source is accepted in this cycle |
| take_id_o | output | $clog2(N_SRC) | Index of the accepted source |
| eoi_i | input | 1 | End-of-handler strobe, retires the top handler |

## Verification
The bench aims at the preemption boundary. A request with equal preemption but a better sub value must wait. A design that compared full priorities would nest it instead. The three-source ordering case under a 2:2 split, and an exact tie resolved by index, catch arbiters that drop the sub field or favour the higher index. Further cases cover a request that arrives while its source is disabled, a grouping change made while a handler runs, and popping the nesting stack in the right order. A broken design would, respectively, lose or prematurely take the disabled request, keep judging preemption with the old split, or clear the wrong active bit.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  localparam int unsigned PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  typedef enum logic [2:0] {
    RG_EN_SET = 3'd0,
    RG_EN_CLR = 3'd1,
    RG_PD_SET = 3'd2,
    RG_PD_CLR = 3'd3,
    RG_ACT    = 3'd4
  } reg_grp_e;

  localparam logic [7:0] GROUP_ADDR = 8'h20;
  localparam logic [7:0] PRIO_BASE  = 8'h40;

  // preemption bits of the nibble, taken from the top
  function automatic prio_t pre_mask(input logic [2:0] grp);
    case (grp)
      3'd7:    return 4'b0000;
      3'd6:    return 4'b1000;
      3'd5:    return 4'b1100;
      3'd4:    return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC = 60,
  localparam int unsigned IDW  = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        cand_i,
  input  prio_t [N_SRC-1:0]       prio_i,
  output logic                    valid_o,
  output logic [IDW-1:0]          id_o,
  output prio_t                   prio_o
);
  // full nibble order equals (preemption, sub) order; strict < keeps lowest index
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '1;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (cand_i[i] && (!valid_o || prio_i[i] < prio_o)) begin
        valid_o = 1'b1;
        id_o    = IDW'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 6,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  push_id_i,
  output logic [W-1:0]  top_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign cnt_o   = cnt_q;
  assign top_o   = mem_q[IW'(cnt_q - CW'(1))];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (push_i && !full_o) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[IW'(cnt_q)] <= push_id_i;
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter int unsigned N_SRC      = 60,
  parameter int unsigned NEST_DEPTH = 16,
  localparam int unsigned IDW       = $clog2(N_SRC),
  localparam int unsigned NWORD     = (N_SRC + 31) / 32,
  localparam int unsigned PADW      = NWORD * 32,
  localparam int unsigned CW        = $clog2(NEST_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             wr_en_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             take_o,
  output logic [IDW-1:0]   take_id_o,
  input  logic             eoi_i
);
  logic [N_SRC-1:0] en_q, pend_q, act_q, irq_q;
  logic [N_SRC-1:0] wbit, take_vec, pop_vec;
  prio_t [N_SRC-1:0] prio_q;
  logic [2:0]       grp_q;
  reg_grp_e         grp_sel;
  logic             lo_wr;

  assign grp_sel = reg_grp_e'(addr_i[4:2]);
  assign lo_wr   = wr_en_i && (addr_i[7:5] == 3'd0);

  // arbitration
  logic             arb_valid;
  prio_t            arb_prio;
  logic [IDW-1:0]   top_id;
  logic             stk_empty, stk_full;
  logic [CW-1:0]    stk_cnt;
  prio_t            mask;
  logic [4:0]       run_lvl;

  irq_nest_arb #(.N_SRC(N_SRC)) i_arb (
    .cand_i  (pend_q & en_q & ~act_q),
    .prio_i  (prio_q),
    .valid_o (arb_valid),
    .id_o    (take_id_o),
    .prio_o  (arb_prio)
  );

  assign mask    = pre_mask(grp_q);
  assign run_lvl = stk_empty ? 5'h10 : {1'b0, prio_q[top_id] & mask};
  assign take_o  = arb_valid && !eoi_i && !stk_full &&
                   ({1'b0, arb_prio & mask} < run_lvl);

  irq_nest_stack #(.DEPTH(NEST_DEPTH), .W(IDW)) i_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (take_o),
    .pop_i     (eoi_i),
    .push_id_i (take_id_o),
    .top_o     (top_id),
    .empty_o   (stk_empty),
    .full_o    (stk_full),
    .cnt_o     (stk_cnt)
  );

  // per-source state
  for (genvar i = 0; i < int'(N_SRC); i++) begin : g_src
    assign wbit[i]     = lo_wr && (addr_i[1:0] == 2'(i / 32)) && wdata_i[i % 32];
    assign take_vec[i] = take_o && (take_id_o == IDW'(i));
    assign pop_vec[i]  = eoi_i && !stk_empty && (top_id == IDW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        pend_q[i] <= 1'b0;
        act_q[i]  <= 1'b0;
        irq_q[i]  <= 1'b0;
        prio_q[i] <= '0;
      end else begin
        irq_q[i] <= irq_i[i];
        if (wbit[i] && grp_sel == RG_EN_SET) en_q[i] <= 1'b1;
        else if (wbit[i] && grp_sel == RG_EN_CLR) en_q[i] <= 1'b0;
        // a new event wins over any clear in the same cycle
        if ((irq_i[i] && !irq_q[i]) || (wbit[i] && grp_sel == RG_PD_SET)) pend_q[i] <= 1'b1;
        else if (take_vec[i] || (wbit[i] && grp_sel == RG_PD_CLR)) pend_q[i] <= 1'b0;
        if (take_vec[i]) act_q[i] <= 1'b1;
        else if (pop_vec[i]) act_q[i] <= 1'b0;
        if (wr_en_i && addr_i == PRIO_BASE + 8'(i)) prio_q[i] <= wdata_i[7:4];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_q <= '0;
    else if (wr_en_i && addr_i == GROUP_ADDR) grp_q <= wdata_i[2:0];
  end

  // read path
  logic [NWORD-1:0][31:0] en_w, pend_w, act_w;
  assign en_w   = PADW'(en_q);
  assign pend_w = PADW'(pend_q);
  assign act_w  = PADW'(act_q);

  always_comb begin
    rdata_o = '0;
    if (addr_i[7:5] == 3'd0) begin
      for (int k = 0; k < int'(NWORD); k++) begin
        if (addr_i[1:0] == 2'(k)) begin
          case (grp_sel)
            RG_EN_SET, RG_EN_CLR: rdata_o = en_w[k];
            RG_PD_SET, RG_PD_CLR: rdata_o = pend_w[k];
            RG_ACT:               rdata_o = act_w[k];
            default:              rdata_o = '0;
          endcase
        end
      end
    end else if (addr_i == GROUP_ADDR) begin
      rdata_o = {29'd0, grp_q};
    end else if (addr_i >= PRIO_BASE && (addr_i - PRIO_BASE) < 8'(N_SRC)) begin
      rdata_o = {24'd0, prio_q[IDW'(addr_i - PRIO_BASE)], 4'd0};
    end
  end
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
  parameter int unsigned N_SRC      = 60,
  parameter int unsigned NEST_DEPTH = 16,
  localparam int unsigned IDW       = $clog2(N_SRC),
  localparam int unsigned CW        = $clog2(NEST_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             take_o,
  input logic [IDW-1:0]   take_id_o,
  input logic             eoi_i,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] act_q,
  input logic [CW-1:0]    stk_cnt,
  input logic             stk_empty
);
  assert_take_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (en_q[take_id_o] && pend_q[take_id_o] && !act_q[take_id_o]));

  assert_take_activates_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> act_q[$past(take_id_o)]);

  assert_active_only_by_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_q & ~$past(act_q)) != '0) |-> $past(take_o));

  assert_stack_tracks_active_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(act_q) == int'(stk_cnt));

  assert_eoi_pops_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !stk_empty) |=> (stk_cnt == $past(stk_cnt) - CW'(1)));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.N_SRC(N_SRC), .NEST_DEPTH(NEST_DEPTH)) i_chk (.*);

// File: tb/test_irq_nest_ctrl.sv
`timescale 1ns/1ps
module test_irq_nest_ctrl;
  localparam int N = 60;
  localparam int IDW = $clog2(N);

  logic clk_i = 0, rst_ni = 0;
  logic [N-1:0] irq_i = '0;
  logic wr_en_i = 0, eoi_i = 0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic take_o;
  logic [IDW-1:0] take_id_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_nest_ctrl #(.N_SRC(N)) i_irq_nest_ctrl (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 0; wdata_i = '0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    addr_i = a; #1;
    check(req, rdata_o, exp);
    @(negedge clk_i);
  endtask

  task automatic wait_take(string req, int id, int max);
    bit seen = 0;
    for (int c = 0; c < max && !seen; c++) begin
      #1;
      if (take_o) begin
        seen = 1;
        check(req, 32'(take_id_o), 32'(id));
      end
      @(negedge clk_i);
    end
    if (!seen) check({req, " no take"}, 32'hFFFF_FFFF, 32'(id));
  endtask

  task automatic no_take(string req, int n);
    for (int c = 0; c < n; c++) begin
      #1;
      check(req, 32'(take_o), 0);
      @(negedge clk_i);
    end
  endtask

  task automatic eoi();
    eoi_i = 1;
    #1; check("R11 no take during eoi", 32'(take_o), 0);
    @(negedge clk_i);
    eoi_i = 0;
  endtask

  task automatic t_reset();
    #1; check("R1 take idle", 32'(take_o), 0);
    rd_chk("R1 enable", 8'h00, 0);
    rd_chk("R1 enable hi", 8'h01, 0);
    rd_chk("R1 pending", 8'h08, 0);
    rd_chk("R1 active", 8'h10, 0);
    rd_chk("R1 group", 8'h20, 0);
    rd_chk("R1 prio", 8'h43, 0);
  endtask

  task automatic t_prio();
    wr(8'h43, 32'hFF);
    rd_chk("R2 low bits zero", 8'h43, 32'hF0);
    wr(8'h43, 32'h9A);
    rd_chk("R2 nibble", 8'h43, 32'h90);
  endtask

  task automatic t_enable();
    wr(8'h00, 32'hC8);
    rd_chk("R4 set", 8'h00, 32'hC8);
    wr(8'h00, 32'h0);
    rd_chk("R4 zero set", 8'h00, 32'hC8);
    wr(8'h04, 32'h08);
    rd_chk("R4 clear", 8'h04, 32'hC0);
    wr(8'h04, 32'h0);
    rd_chk("R4 zero clear", 8'h00, 32'hC0);
    wr(8'h00, 32'h08);
    wr(8'h01, 32'h0800_0000);
    rd_chk("R4 upper word", 8'h01, 32'h0800_0000);
    wr(8'h05, 32'h0800_0000);
    rd_chk("R4 upper clear", 8'h01, 0);
  endtask

  task automatic t_pending();
    wr(8'h09, 32'h0080_0000);
    rd_chk("R5 set", 8'h09, 32'h0080_0000);
    no_take("R5 disabled pending", 2);
    wr(8'h0D, 32'h0);
    rd_chk("R5 zero clear", 8'h0D, 32'h0080_0000);
    wr(8'h0D, 32'h0080_0000);
    rd_chk("R5 clear", 8'h09, 0);
  endtask

  task automatic t_example();
    wr(8'h20, 32'd5);
    wr(8'h46, 32'hC0);
    wr(8'h47, 32'h80);
    wr(8'h08, 32'hC8);
    wait_take("R10 first of three", 7, 1);
    rd_chk("R8 active set", 8'h10, 32'h80);
    rd_chk("R8 pending cleared", 8'h08, 32'h48);
    no_take("R9 equal preemption waits", 4);
    eoi();
    wait_take("R10 second of three", 3, 1);
    eoi();
    wait_take("R10 third of three", 6, 1);
    eoi();
    rd_chk("R7 all retired", 8'h10, 0);
  endtask

  task automatic t_nesting();
    wr(8'h20, 32'd3);
    wr(8'h4A, 32'hA0);
    wr(8'h4B, 32'h50);
    wr(8'h00, 32'hC00);
    wr(8'h08, 32'h400);
    wait_take("R8 idle accept", 10, 1);
    rd_chk("R7 active outer", 8'h10, 32'h400);
    wr(8'h08, 32'h800);
    wait_take("R8 nested preempt", 11, 1);
    rd_chk("R7 active nested", 8'h10, 32'hC00);
    eoi();
    rd_chk("R11 inner retired", 8'h10, 32'h400);
    eoi();
    rd_chk("R11 outer retired", 8'h10, 0);
  endtask

  task automatic t_edge();
    irq_i[30] = 1;
    @(negedge clk_i);
    rd_chk("R6 edge pends disabled", 8'h08, 32'h4000_0000);
    no_take("R6 disabled not taken", 3);
    wr(8'h00, 32'h4000_0000);
    wait_take("R6 taken once enabled", 30, 1);
    rd_chk("R6 held level no repend", 8'h08, 0);
    eoi();
    irq_i[30] = 0;
  endtask

  task automatic t_tie();
    wr(8'h72, 32'h70);
    wr(8'h6D, 32'h70);
    wr(8'h01, 32'h0004_2000);
    wr(8'h09, 32'h0004_2000);
    wait_take("R10 index tie", 45, 1);
    no_take("R9 tie waits", 2);
    eoi();
    wait_take("R10 tie second", 50, 1);
    eoi();
  endtask

  task automatic t_group_change();
    wr(8'h20, 32'd7);
    wr(8'h68, 32'h60);
    wr(8'h69, 32'h40);
    wr(8'h01, 32'h300);
    wr(8'h09, 32'h100);
    wait_take("R12 base handler", 40, 1);
    wr(8'h09, 32'h200);
    no_take("R3 no preemption bits", 3);
    wr(8'h20, 32'd3);
    wait_take("R12 regroup preempts", 41, 1);
    rd_chk("R12 stack kept", 8'h11, 32'h300);
    eoi();
    rd_chk("R12 pop order", 8'h11, 32'h100);
    eoi();
    rd_chk("R12 empty", 8'h11, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_prio();
    t_enable();
    t_pending();
    t_example();
    t_nesting();
    t_edge();
    t_tie();
    t_group_change();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule